// File: doc/BRIEF.md
# UART Receive Buffer Closer

This block sits behind a UART receiver and packs received characters into fixed-length receive buffers. Each accepted character is written through a simple write port at the next free offset of the current buffer. The block decides when the current buffer ends. When it ends, it reports a close with a one-hot reason and a byte count, raises an interrupt pulse, and starts the next character at offset zero.

Four conditions can end a buffer: a receive error, a character that equals the programmed control character, a buffer that has reached its configured length, and a configured run of idle character times with no character. The control-character comparison honours the 7/8-bit setting. A reject setting turns a matching character into one that is dropped. All outputs are registered. The write and the close that a character causes both appear in the cycle after the strobe.

Top module: `uart_rxbuf_closer`

## Requirements
- R1: While rst_ni is low and in the first cycle after release, wr_en_o, close_o, irq_o, close_status_o, close_count_o, wr_addr_o and wr_data_o are all zero.
- R2: A stored character sampled with char_valid_i produces wr_en_o in the next cycle. wr_addr_o equals the number of bytes already in the current buffer (0, 1, 2, ...). wr_data_o carries the character. With no char_valid_i the next cycle has no write.
- R3: When cfg_seven_bit_i is 1, bit 7 of wr_data_o is written as 0, and the control-character compare uses bits 6:0 only.
- R4: With cfg_reject_i at 0, a character matching cfg_ctrl_char_i is stored as the last byte, and the buffer closes with reason bit 1 (control).
- R5: With cfg_reject_i at 1, a matching character is dropped: no write and no control close. The next stored character takes the offset the dropped one would have used.
- R6: err_i closes the buffer with reason bit 0 (error), even when the buffer is empty. A character strobed in the same cycle is stored first and counted.
- R7: When a store brings the byte count to cfg_buf_len_i, the buffer closes with reason bit 2 (full) and close_count_o equal to cfg_buf_len_i.
- R8: Idle ticks are counted, and the count restarts on every character strobe, on every close, and when a tick coincides with a character. The tick that makes cfg_max_idle_i consecutive ticks closes the buffer with reason bit 3 (idle). A cfg_max_idle_i of 0 disables idle closes.
- R9: An idle expiry with an empty buffer produces no close.
- R10: When several conditions occur together, exactly one reason bit is set, chosen by the priority error, then control, then full, then idle. close_count_o gives the bytes in the closed buffer.
- R11: After a close, the next stored character is written at offset 0.
- R12: irq_o is a one-cycle pulse in the close cycle when irq_mask_i was 0 at the triggering strobe. It stays 0 when the mask was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_valid_i | input | 1 | Received character strobe |
| char_data_i | input | DATA_W | Received character |
| err_i | input | 1 | Framing or parity error strobe |
| idle_tick_i | input | 1 | One idle character time elapsed |
| cfg_buf_len_i | input | CNT_W | Buffer length in bytes |
| cfg_ctrl_char_i | input | DATA_W | Control character to match |
| cfg_reject_i | input | 1 | 1: drop matching characters |
| cfg_max_idle_i | input | IDLE_W | Idle ticks before close, 0 disables |
| cfg_seven_bit_i | input | 1 | 1: 7-bit characters |
| irq_mask_i | input | 1 | 1: suppress interrupt |
| wr_en_o | output | 1 | Buffer write enable |
| wr_addr_o | output | CNT_W | Byte offset in current buffer |
| wr_data_o | output | DATA_W | Byte to write |
| close_o | output | 1 | Buffer closed this cycle |
| close_status_o | output | 4 | One-hot reason: bit0 error, bit1 control, bit2 full, bit3 idle |
| close_count_o | output | CNT_W | Bytes in the closed buffer |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest cases are the coincident closes. One is a control character landing exactly in the last free slot, where control must win over full. Another is an error strobe that arrives with a character, which must still be stored and counted. A third is an idle run that expires on an empty buffer. A vector table, run with a four-byte buffer and a three-tick idle limit, reaches each of these: it fills slots up to the one before last, lets idle runs expire just after closes, and pairs strobes on the same cycle. Directed runs then change the 7-bit, reject, mask and idle-disable settings.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int NUM_RSN  = 4;
  localparam int RSN_ERR  = 0;
  localparam int RSN_CTRL = 1;
  localparam int RSN_FULL = 2;
  localparam int RSN_IDLE = 3;
endpackage

// File: rtl/rxbuf_char_filter.sv
module rxbuf_char_filter #(
  parameter int DATA_W = 8
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] ctrl_i,
  input  logic              reject_i,
  input  logic              seven_bit_i,
  output logic              store_o,
  output logic              ctrl_close_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] keep_mask;
  logic              match;

  always_comb begin
    keep_mask = '1;
    if (seven_bit_i) keep_mask[MSB] = 1'b0;
  end

  assign match        = ((data_i ^ ctrl_i) & keep_mask) == '0;
  assign data_o       = data_i & keep_mask;
  assign store_o      = valid_i & ~(match & reject_i);
  assign ctrl_close_o = valid_i & match & ~reject_i;
endmodule

// File: rtl/rxbuf_idle_counter.sv
module rxbuf_idle_counter #(
  parameter int IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              char_i,
  input  logic              clear_i,
  input  logic [IDLE_W-1:0] max_i,
  output logic              expire_o
);
  logic [IDLE_W-1:0] cnt_q;
  logic [IDLE_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign expire_o = tick_i & ~char_i & (max_i != '0) & (cnt_inc >= {1'b0, max_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (char_i || clear_i)    cnt_q <= '0;
    else if (tick_i && cnt_q < max_i) cnt_q <= cnt_inc[IDLE_W-1:0];
  end
endmodule

// File: rtl/rxbuf_close_arbiter.sv
module rxbuf_close_arbiter #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  // lowest index wins
  for (genvar i = 0; i < N; i++) begin : g_prio
    assign gnt_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end
endmodule

// File: rtl/uart_rxbuf_closer.sv
module uart_rxbuf_closer
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              err_i,
  input  logic              idle_tick_i,
  input  logic [CNT_W-1:0]  cfg_buf_len_i,
  input  logic [DATA_W-1:0] cfg_ctrl_char_i,
  input  logic              cfg_reject_i,
  input  logic [IDLE_W-1:0] cfg_max_idle_i,
  input  logic              cfg_seven_bit_i,
  input  logic              irq_mask_i,
  output logic              wr_en_o,
  output logic [CNT_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              close_o,
  output logic [NUM_RSN-1:0] close_status_o,
  output logic [CNT_W-1:0]  close_count_o,
  output logic              irq_o
);
  logic              store, ctrl_close, idle_expire, close_now;
  logic [DATA_W-1:0] store_data;
  logic [CNT_W-1:0]  fill_q;
  logic [CNT_W:0]    new_cnt;
  logic [NUM_RSN-1:0] req, gnt;

  rxbuf_char_filter #(.DATA_W(DATA_W)) u_filter (
    .valid_i      (char_valid_i),
    .data_i       (char_data_i),
    .ctrl_i       (cfg_ctrl_char_i),
    .reject_i     (cfg_reject_i),
    .seven_bit_i  (cfg_seven_bit_i),
    .store_o      (store),
    .ctrl_close_o (ctrl_close),
    .data_o       (store_data)
  );

  rxbuf_idle_counter #(.IDLE_W(IDLE_W)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (idle_tick_i),
    .char_i   (char_valid_i),
    .clear_i  (close_now),
    .max_i    (cfg_max_idle_i),
    .expire_o (idle_expire)
  );

  assign new_cnt = {1'b0, fill_q} + {{CNT_W{1'b0}}, store};

  always_comb begin
    req           = '0;
    req[RSN_ERR]  = err_i;
    req[RSN_CTRL] = ctrl_close;
    req[RSN_FULL] = store & (new_cnt >= {1'b0, cfg_buf_len_i});
    req[RSN_IDLE] = idle_expire & (fill_q != '0);
  end

  rxbuf_close_arbiter #(.N(NUM_RSN)) u_arb (
    .req_i (req),
    .gnt_o (gnt)
  );

  assign close_now = |req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q         <= '0;
      wr_en_o        <= 1'b0;
      wr_addr_o      <= '0;
      wr_data_o      <= '0;
      close_o        <= 1'b0;
      close_status_o <= '0;
      close_count_o  <= '0;
      irq_o          <= 1'b0;
    end else begin
      fill_q         <= close_now ? '0 : new_cnt[CNT_W-1:0];
      wr_en_o        <= store;
      wr_addr_o      <= store ? fill_q : '0;
      wr_data_o      <= store ? store_data : '0;
      close_o        <= close_now;
      close_status_o <= gnt;
      close_count_o  <= close_now ? new_cnt[CNT_W-1:0] : '0;
      irq_o          <= close_now & ~irq_mask_i;
    end
  end
endmodule

// File: rtl/rxbuf_closer_chk.sv
module rxbuf_closer_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              char_valid_i,
  input logic [DATA_W-1:0] char_data_i,
  input logic              err_i,
  input logic [DATA_W-1:0] cfg_ctrl_char_i,
  input logic              cfg_reject_i,
  input logic              cfg_seven_bit_i,
  input logic              irq_mask_i,
  input logic              wr_en_o,
  input logic [CNT_W-1:0]  wr_addr_o,
  input logic              wr_msb_i,
  input logic              close_o,
  input logic [3:0]        close_status_o,
  input logic [CNT_W-1:0]  close_count_o,
  input logic              irq_o
);
  a_r2_no_spurious_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(char_valid_i) |-> !wr_en_o);

  a_r3_msb_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && $past(cfg_seven_bit_i) |-> !wr_msb_i);

  a_r5_reject_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(char_valid_i && cfg_reject_i && !cfg_seven_bit_i && char_data_i == cfg_ctrl_char_i)
    |-> !wr_en_o && !close_status_o[1]);

  a_r6_err_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_i) |-> close_o && close_status_o[0]);

  a_r9_idle_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o && close_status_o[3] |-> close_count_o != '0);

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |-> $countones(close_status_o) == 1);

  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close_o |-> close_status_o == '0);

  a_r11_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |=> !wr_en_o || wr_addr_o == '0);

  a_r12_irq_needs_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> close_o);

  a_r12_irq_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o && !$past(irq_mask_i) |-> irq_o);
endmodule

bind uart_rxbuf_closer rxbuf_closer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .char_valid_i    (char_valid_i),
  .char_data_i     (char_data_i),
  .err_i           (err_i),
  .cfg_ctrl_char_i (cfg_ctrl_char_i),
  .cfg_reject_i    (cfg_reject_i),
  .cfg_seven_bit_i (cfg_seven_bit_i),
  .irq_mask_i      (irq_mask_i),
  .wr_en_o         (wr_en_o),
  .wr_addr_o       (wr_addr_o),
  .wr_msb_i        (wr_data_o[DATA_W-1]),
  .close_o         (close_o),
  .close_status_o  (close_status_o),
  .close_count_o   (close_count_o),
  .irq_o           (irq_o)
);

// File: tb/uart_rxbuf_closer_tb.sv
`timescale 1ns/1ps
module uart_rxbuf_closer_tb;
  localparam int NV = 29;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       char_valid_i = 1'b0;
  logic [7:0] char_data_i = '0;
  logic       err_i = 1'b0;
  logic       idle_tick_i = 1'b0;
  logic [7:0] cfg_buf_len_i = 8'd4;
  logic [7:0] cfg_ctrl_char_i = 8'h0D;
  logic       cfg_reject_i = 1'b0;
  logic [7:0] cfg_max_idle_i = 8'd3;
  logic       cfg_seven_bit_i = 1'b0;
  logic       irq_mask_i = 1'b0;
  logic       wr_en_o, close_o, irq_o;
  logic [7:0] wr_addr_o, wr_data_o, close_count_o;
  logic [3:0] close_status_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  uart_rxbuf_closer u_dut (.*);

  // {valid, data, err, tick, | wr, addr, data, close, status{idle,full,ctrl,err}, count, irq}
  localparam logic [41:0] VEC [NV] = '{
    {1'b1,8'h41,1'b0,1'b0, 1'b1,8'd0,8'h41,1'b0,4'b0000,8'd0,1'b0}, // R2
    {1'b1,8'h42,1'b0,1'b0, 1'b1,8'd1,8'h42,1'b0,4'b0000,8'd0,1'b0}, // R2
    {1'b1,8'h0D,1'b0,1'b0, 1'b1,8'd2,8'h0D,1'b1,4'b0010,8'd3,1'b1}, // R4
    {1'b1,8'h10,1'b0,1'b0, 1'b1,8'd0,8'h10,1'b0,4'b0000,8'd0,1'b0}, // R11
    {1'b0,8'h00,1'b0,1'b1, 1'b0,8'd0,8'h00,1'b0,4'b0000,8'd0,1'b0}, // R8
    {1'b0,8'h00,1'b0,1'b1, 1'b0,8'd0,8'h00,1'b0,4'b0000,8'd0,1'b0}, // R8
    {1'b1,8'h11,1'b0,1'b0, 1'b1,8'd1,8'h11,1'b0,4'b0000,8'd0,1'b0}, // R8 restart
    {1'b0,8'h00,1'b0,1'b1, 1'b0,8'd0,8'h00,1'b0,4'b0000,8'd0,1'b0}, // R8
    {1'b0,8'h00,1'b0,1'b1, 1'b0,8'd0,8'h00,1'b0,4'b0000,8'd0,1'b0}, // R8
    {1'b0,8'h00,1'b0,1'b1, 1'b0,8'd0,8'h00,1'b1,4'b1000,8'd2,1'b1}, // R8 idle close
    {1'b0,8'h00,1'b0,1'b1, 1'b0,8'd0,8'h00,1'b0,4'b0000,8'd0,1'b0}, // R9
    {1'b0,8'h00,1'b0,1'b1, 1'b0,8'd0,8'h00,1'b0,4'b0000,8'd0,1'b0}, // R9
    {1'b0,8'h00,1'b0,1'b1, 1'b0,8'd0,8'h00,1'b0,4'b0000,8'd0,1'b0}, // R9 empty expiry
    {1'b1,8'h20,1'b0,1'b0, 1'b1,8'd0,8'h20,1'b0,4'b0000,8'd0,1'b0}, // R7
    {1'b1,8'h21,1'b0,1'b0, 1'b1,8'd1,8'h21,1'b0,4'b0000,8'd0,1'b0}, // R7
    {1'b1,8'h22,1'b0,1'b0, 1'b1,8'd2,8'h22,1'b0,4'b0000,8'd0,1'b0}, // R7
    {1'b1,8'h23,1'b0,1'b0, 1'b1,8'd3,8'h23,1'b1,4'b0100,8'd4,1'b1}, // R7 full
    {1'b1,8'h30,1'b0,1'b0, 1'b1,8'd0,8'h30,1'b0,4'b0000,8'd0,1'b0}, // R11
    {1'b0,8'h00,1'b1,1'b0, 1'b0,8'd0,8'h00,1'b1,4'b0001,8'd1,1'b1}, // R6
    {1'b1,8'h0D,1'b1,1'b0, 1'b1,8'd0,8'h0D,1'b1,4'b0001,8'd1,1'b1}, // R10 err over ctrl
    {1'b0,8'h00,1'b1,1'b0, 1'b0,8'd0,8'h00,1'b1,4'b0001,8'd0,1'b1}, // R6 empty
    {1'b1,8'h01,1'b0,1'b0, 1'b1,8'd0,8'h01,1'b0,4'b0000,8'd0,1'b0}, // R2
    {1'b1,8'h02,1'b0,1'b0, 1'b1,8'd1,8'h02,1'b0,4'b0000,8'd0,1'b0}, // R2
    {1'b1,8'h03,1'b0,1'b0, 1'b1,8'd2,8'h03,1'b0,4'b0000,8'd0,1'b0}, // R2
    {1'b1,8'h0D,1'b0,1'b0, 1'b1,8'd3,8'h0D,1'b1,4'b0010,8'd4,1'b1}, // R10 ctrl over full
    {1'b1,8'hFF,1'b0,1'b1, 1'b1,8'd0,8'hFF,1'b0,4'b0000,8'd0,1'b0}, // R8 tick with char
    {1'b0,8'h00,1'b0,1'b1, 1'b0,8'd0,8'h00,1'b0,4'b0000,8'd0,1'b0}, // R8
    {1'b0,8'h00,1'b0,1'b1, 1'b0,8'd0,8'h00,1'b0,4'b0000,8'd0,1'b0}, // R8
    {1'b0,8'h00,1'b0,1'b1, 1'b0,8'd0,8'h00,1'b1,4'b1000,8'd1,1'b1}  // R8
  };

  function automatic logic [30:0] obs();
    return {wr_en_o, wr_addr_o, wr_data_o, close_o, close_status_o, close_count_o, irq_o};
  endfunction

  task automatic check(input string req, input logic [30:0] act, input logic [30:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic e, input logic t);
    @(negedge clk_i);
    char_valid_i = v; char_data_i = d; err_i = e; idle_tick_i = t;
    @(posedge clk_i);
    #5;
    @(negedge clk_i);
    char_valid_i = 1'b0; err_i = 1'b0; idle_tick_i = 1'b0;
  endtask

  task automatic step_fast(input logic v, input logic [7:0] d, input logic e, input logic t);
    @(negedge clk_i);
    char_valid_i = v; char_data_i = d; err_i = e; idle_tick_i = t;
    @(posedge clk_i);
    #5;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    check("R1 in reset", obs(), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #5;
    check("R1 after release", obs(), '0);

    for (int i = 0; i < NV; i++) begin
      step_fast(VEC[i][41], VEC[i][40:33], VEC[i][32], VEC[i][31]);
      check($sformatf("table vector %0d", i), obs(), VEC[i][30:0]);
    end
    @(negedge clk_i);
    char_valid_i = 1'b0; err_i = 1'b0; idle_tick_i = 1'b0;

    // R3 seven-bit storage and compare
    cfg_seven_bit_i = 1'b1;
    step(1'b1, 8'hC1, 1'b0, 1'b0);
    check("R3 msb cleared", obs(), {1'b1,8'd0,8'h41,1'b0,4'b0000,8'd0,1'b0});
    step_fast(1'b1, 8'h8D, 1'b0, 1'b0);
    check("R3 ctrl match on low bits", obs(), {1'b1,8'd1,8'h0D,1'b1,4'b0010,8'd2,1'b1});
    @(negedge clk_i);
    char_valid_i = 1'b0;
    cfg_seven_bit_i = 1'b0;

    // R5 reject drops matching character
    cfg_reject_i = 1'b1;
    step(1'b1, 8'h0D, 1'b0, 1'b0);
    check("R5 dropped, no write no close", obs(), '0);
    step(1'b1, 8'h44, 1'b0, 1'b0);
    check("R5 next offset unchanged", obs(), {1'b1,8'd0,8'h44,1'b0,4'b0000,8'd0,1'b0});
    cfg_reject_i = 1'b0;

    // R12 masked interrupt
    irq_mask_i = 1'b1;
    step(1'b0, 8'h00, 1'b1, 1'b0);
    check("R12 masked close", obs(), {1'b0,8'd0,8'h00,1'b1,4'b0001,8'd1,1'b0});
    irq_mask_i = 1'b0;
    @(posedge clk_i); #5;
    check("R12 irq single pulse", {30'd0, irq_o}, '0);

    // R8 idle limit of zero disables idle closes
    cfg_max_idle_i = 8'd0;
    step(1'b1, 8'h50, 1'b0, 1'b0);
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        step(1'b0, 8'h00, 1'b0, 1'b1);
        if (close_o) seen++;
      end
      check("R8 max idle zero no close", {30'd0, seen != 0}, '0);
    end
    cfg_max_idle_i = 8'd3;

    // R7 length one: each character closes full
    cfg_buf_len_i = 8'd1;
    step(1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b1, 8'h60, 1'b0, 1'b0);
    check("R7 length one", obs(), {1'b1,8'd0,8'h60,1'b1,4'b0100,8'd1,1'b1});
    step(1'b1, 8'h61, 1'b0, 1'b0);
    check("R11 offset zero again", obs(), {1'b1,8'd0,8'h61,1'b1,4'b0100,8'd1,1'b1});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule